// File: doc/BRIEF.md
# Erase-With-Verify Sequencer

This block sits on the host side of a flash command port and carries out an erase followed by a verify of the erased range. A single start pulse launches the whole procedure. The block switches the flash into its verify mode, then issues the selected erase (whole array, one block or one sector). It waits for the internal operation to finish by polling a toggling status bit. It then reads every word of the requested address range and expects all ones.

When a word is not yet erased, the erase is issued again. The scan then resumes at the word that failed instead of starting over. One retry counter bounds the total number of erases across the whole range. Once that budget runs out the block stops and flags an error. In either outcome it leaves verify mode with the three-cycle exit command before it reports.

The flash side is reached through a simple request/acknowledge port: one word per transfer, either a command write or a data read. The host sees a busy level and single-cycle done and error pulses.

Top module: `erase_verify_ctrl`

## Requirements
- R1: A start pulse while idle latches the low and high range bounds and the erase kind, and clears the scan address and the retry count. A start pulse while busy is ignored, and so are changes on the range and kind inputs after the start is taken.
- R2: The first commands are the verify-entry sequence (5555/AA, 2AAA/55, 5555/80, 5555/AA, 2AAA/55, 5555/B0). It is issued once and is followed by the erase sequence. The erase sequence has the same five-cycle prefix and then a final cycle chosen by kind: 00 or 11 gives 5555/10 (whole array), 01 gives range-low/50 (block), 10 gives range-low/30 (sector). Command addresses are zero-extended and the upper data byte is 0.
- R3: After every erase the block reads the current scan address repeatedly. It leaves polling only when two consecutive reads agree in bit 6, and it issues no write while the flash is still busy.
- R4: The scan reads each address from range-low to range-high in ascending order with no gaps, and compares each word against all ones. A full pass ends after the read of range-high.
- R5: A word that is not all ones increments the retry count and triggers a new erase. After that erase and its polling, reading resumes at the failing address, with no read below it.
- R6: When the mismatch count reaches RETRY_LIMIT (default 100), no further erase is issued. The total number of erases in that run equals RETRY_LIMIT and the run ends with an error.
- R7: The exit sequence (5555/AA, 2AAA/55, 5555/F0) is issued exactly once, after the last erase, on both the success path and the error path.
- R8: done_o and err_o are single-cycle pulses that never coincide, and exactly one of them occurs per run. busy_o is high from the cycle after the start is taken through the pulse cycle, and low afterwards.
- R9: While bus_req_o is high and bus_ack_i is low, the address, direction and write data stay unchanged. A transfer completes on a clock edge where both bus_req_o and bus_ack_i are high, and read data is sampled on that edge.
- R10: Out of reset, busy_o, bus_req_o, done_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| kind_i | input | 2 | Erase kind: 00/11 whole array, 01 block, 10 sector |
| range_lo_i | input | AW | First address to verify; also the block/sector target |
| range_hi_i | input | AW | Last address to verify (not below range_lo_i) |
| bus_req_o | output | 1 | Transfer request |
| bus_we_o | output | 1 | 1 = command write, 0 = read |
| bus_addr_o | output | AW | Transfer address |
| bus_wdata_o | output | DW | Write data |
| bus_ack_i | input | 1 | Transfer acknowledge |
| bus_rdata_i | input | DW | Read data, valid with the acknowledge |
| busy_o | output | 1 | Procedure in progress |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Retry budget exhausted pulse |

## Verification
The hardest situation to reach is the exact edge of the retry budget. A word must stay unerased through RETRY_LIMIT-1 erases and clear on the last one, and a neighbouring case needs one erase more, so that success and error are separated by a single erase. The flash model holds per-address erase-resistance counts. Directed cases place these at exactly the limit and one above it, and random cases place several resistant words at scattered offsets, so that a later word has already been partly cleared by the re-erases caused by an earlier one. The model also holds the busy status for a random number of reads and acknowledges after random delays, which catches polling that ends too early and scans that resume at the wrong address.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ENTRY, S_ERASE, S_POLL, S_SCAN, S_EXIT, S_FIN
  } state_e;

  typedef enum logic [1:0] {SEQ_ENTRY, SEQ_ERASE, SEQ_EXIT} seq_e;

  localparam logic [1:0] KIND_BLOCK  = 2'b01;
  localparam logic [1:0] KIND_SECTOR = 2'b10;

  localparam logic [14:0] CA_HI = 15'h5555;
  localparam logic [14:0] CA_LO = 15'h2AAA;

  localparam logic [7:0] CODE_UNLK1  = 8'hAA;
  localparam logic [7:0] CODE_UNLK2  = 8'h55;
  localparam logic [7:0] CODE_SETUP  = 8'h80;
  localparam logic [7:0] CODE_VENTRY = 8'hB0;
  localparam logic [7:0] CODE_EXIT   = 8'hF0;
  localparam logic [7:0] CODE_ALL    = 8'h10;
  localparam logic [7:0] CODE_BLOCK  = 8'h50;
  localparam logic [7:0] CODE_SECTOR = 8'h30;
endpackage

// File: rtl/evc_cmd_table.sv
module evc_cmd_table
  import evc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  seq_e          seq_i,
  input  logic [2:0]    step_i,
  input  logic [1:0]    kind_i,
  input  logic [AW-1:0] tgt_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          last_o
);
  logic [14:0] caddr;
  logic [7:0]  code;
  logic        use_tgt;

  always_comb begin
    caddr   = CA_HI;
    code    = CODE_UNLK1;
    use_tgt = 1'b0;
    last_o  = 1'b0;
    case (step_i)
      3'd0, 3'd3: begin caddr = CA_HI; code = CODE_UNLK1; end
      3'd1, 3'd4: begin caddr = CA_LO; code = CODE_UNLK2; end
      3'd2: begin
        caddr  = CA_HI;
        code   = (seq_i == SEQ_EXIT) ? CODE_EXIT : CODE_SETUP;
        last_o = (seq_i == SEQ_EXIT);
      end
      default: begin
        last_o = 1'b1;
        if (seq_i == SEQ_ENTRY) code = CODE_VENTRY;
        else if (kind_i == KIND_BLOCK) begin code = CODE_BLOCK; use_tgt = 1'b1; end
        else if (kind_i == KIND_SECTOR) begin code = CODE_SECTOR; use_tgt = 1'b1; end
        else code = CODE_ALL;
      end
    endcase
  end

  assign addr_o = use_tgt ? tgt_i : {{(AW-15){1'b0}}, caddr};
  assign data_o = {{(DW-8){1'b0}}, code};
endmodule

// File: rtl/evc_retry_ctr.sv
module evc_retry_ctr #(
  parameter int LIMIT = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic final_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  // next mismatch is the one that exhausts the budget
  assign final_o = (cnt_q == CW'(LIMIT - 1));

  AST_RETRY_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LIMIT)); // R6
  AST_NO_INC_PAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_q == CW'(LIMIT - 1)) |=> cnt_q == CW'(LIMIT)); // R6
endmodule

// File: rtl/erase_verify_ctrl.sv
module erase_verify_ctrl
  import evc_pkg::*;
#(
  parameter int AW          = 20,
  parameter int DW          = 16,
  parameter int RETRY_LIMIT = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    kind_i,
  input  logic [AW-1:0] range_lo_i,
  input  logic [AW-1:0] range_hi_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int STAT_BIT = 6;

  state_e        state_q;
  logic [2:0]    step_q;
  logic [AW-1:0] lo_q, hi_q, cur_q;
  logic [1:0]    kind_q;
  logic          prev_q, have_prev_q, fail_q;
  seq_e          seq;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic          cmd_last, retry_final, xfer, rd_ones, take_start;

  always_comb begin
    case (state_q)
      S_ENTRY: seq = SEQ_ENTRY;
      S_EXIT:  seq = SEQ_EXIT;
      default: seq = SEQ_ERASE;
    endcase
  end

  evc_cmd_table #(.AW(AW), .DW(DW)) u_table (
    .seq_i (seq),
    .step_i(step_q),
    .kind_i(kind_q),
    .tgt_i (lo_q),
    .addr_o(cmd_addr),
    .data_o(cmd_data),
    .last_o(cmd_last)
  );

  assign take_start = (state_q == S_IDLE) && start_i;
  assign bus_req_o  = (state_q == S_ENTRY) || (state_q == S_ERASE) || (state_q == S_POLL)
                   || (state_q == S_SCAN)  || (state_q == S_EXIT);
  assign bus_we_o   = (state_q == S_ENTRY) || (state_q == S_ERASE) || (state_q == S_EXIT);
  assign bus_addr_o = bus_we_o ? cmd_addr : cur_q;
  assign bus_wdata_o = bus_we_o ? cmd_data : '0;
  assign xfer       = bus_req_o && bus_ack_i;
  assign rd_ones    = &bus_rdata_i;

  evc_retry_ctr #(.LIMIT(RETRY_LIMIT)) u_retry (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (take_start),
    .inc_i  ((state_q == S_SCAN) && xfer && !rd_ones),
    .final_o(retry_final)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      step_q      <= '0;
      lo_q        <= '0;
      hi_q        <= '0;
      cur_q       <= '0;
      kind_q      <= '0;
      prev_q      <= 1'b0;
      have_prev_q <= 1'b0;
      fail_q      <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          lo_q    <= range_lo_i;
          hi_q    <= range_hi_i;
          cur_q   <= range_lo_i;
          kind_q  <= kind_i;
          fail_q  <= 1'b0;
          step_q  <= '0;
          state_q <= S_ENTRY;
        end
        S_ENTRY, S_ERASE, S_EXIT: if (xfer) begin
          if (!cmd_last) step_q <= step_q + 3'd1;
          else begin
            step_q      <= '0;
            have_prev_q <= 1'b0;
            case (state_q)
              S_ENTRY: state_q <= S_ERASE;
              S_ERASE: state_q <= S_POLL;
              default: state_q <= S_FIN;
            endcase
          end
        end
        S_POLL: if (xfer) begin
          // busy while bit 6 flips between consecutive reads
          if (have_prev_q && (bus_rdata_i[STAT_BIT] == prev_q)) state_q <= S_SCAN;
          prev_q      <= bus_rdata_i[STAT_BIT];
          have_prev_q <= 1'b1;
        end
        S_SCAN: if (xfer) begin
          if (rd_ones) begin
            if (cur_q == hi_q) state_q <= S_EXIT;
            else cur_q <= cur_q + 1'b1;
          end else if (retry_final) begin
            fail_q  <= 1'b1;
            state_q <= S_EXIT;
          end else begin
            state_q <= S_ERASE;
          end
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = (state_q == S_FIN) && !fail_q;
  assign err_o  = (state_q == S_FIN) && fail_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)
                                   && $stable(bus_wdata_o))); // R9
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R8
  AST_PULSE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |=> (!busy_o && !done_o && !err_o)); // R8
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o || err_o)); // R8
  AST_READ_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_we_o) |-> (bus_addr_o >= lo_q && bus_addr_o <= hi_q)); // R4
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && !err_o) |=> $stable(lo_q) && $stable(hi_q)); // R1
endmodule

// File: tb/erase_verify_ctrl_bench.sv
module erase_verify_ctrl_bench;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int LIM = 100;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    kind_i = '0;
  logic [AW-1:0] range_lo_i = '0, range_hi_i = '0;
  logic          bus_req_o, bus_we_o, busy_o, done_o, err_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_wdata_o;
  logic          bus_ack_i = 1'b0;
  logic [DW-1:0] bus_rdata_i = '0;

  erase_verify_ctrl #(.AW(AW), .DW(DW), .RETRY_LIMIT(LIM)) u_erase_verify_ctrl (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  // flash model state
  int st_addr[4], st_need[4], n_st;
  int seq_pos, n_entry, n_erase, n_exit, n_done, n_err;
  int seq_err, poll_err, order_err, resume_err, stab_err, busy_err;
  int busy_reads, wait_cnt, max_rd;
  bit tog, have_rd, after_erase, pend, watch;
  logic [AW-1:0] last_rd, cur_lo, pend_addr;
  logic [DW-1:0] pend_data;
  logic [1:0]    cur_kind;
  logic          pend_we;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
    for (int i = 0; i < n_st; i++)
      if (st_addr[i] == int'(a) && st_need[i] > 0) return 16'h0F0F;
    return '1;
  endfunction

  function automatic int max_need();
    int m = 1;
    for (int i = 0; i < n_st; i++) if (st_need[i] > m) m = st_need[i];
    return m;
  endfunction

  task automatic on_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [7:0] c = d[7:0];
    if (busy_reads > 0) poll_err++;
    if (d[15:8] != 0) seq_err++;
    case (seq_pos)
      0, 3: if (a != 20'h05555 || c != 8'hAA) seq_err++;
      1, 4: if (a != 20'h02AAA || c != 8'h55) seq_err++;
      2: if (a != 20'h05555) seq_err++;
      default: ;
    endcase
    if (seq_pos == 2 && c == 8'hF0) begin
      n_exit++;
      if (n_erase == 0 || n_exit > 1) seq_err++;
      seq_pos = 0;
    end else if (seq_pos == 2 && c != 8'h80) begin
      seq_err++; seq_pos++;
    end else if (seq_pos == 5) begin
      seq_pos = 0;
      if (c == 8'hB0) begin
        n_entry++;
        if (a != 20'h05555 || n_erase > 0) seq_err++;
      end else begin
        logic [7:0] ec = (cur_kind == 2'b01) ? 8'h50 : (cur_kind == 2'b10) ? 8'h30 : 8'h10;
        logic [AW-1:0] ea = (cur_kind == 2'b01 || cur_kind == 2'b10) ? cur_lo : 20'h05555;
        if (c != ec || a != ea || n_entry != 1 || n_exit != 0) seq_err++;
        n_erase++;
        for (int i = 0; i < n_st; i++) if (st_need[i] > 0) st_need[i]--;
        busy_reads = $urandom % 4;
        after_erase = 1;
      end
    end else seq_pos++;
  endtask

  task automatic on_read(input logic [AW-1:0] a);
    if (!have_rd) begin
      if (a != cur_lo) order_err++;
    end else if (after_erase) begin
      if (a != last_rd) resume_err++;
    end else if (a != last_rd && a != last_rd + 1'b1) order_err++;
    after_erase = 0;
    have_rd = 1; last_rd = a;
    if (int'(a) > max_rd) max_rd = int'(a);
    if (busy_reads > 0) begin
      busy_reads--; tog = ~tog;
      bus_rdata_i = '0; bus_rdata_i[6] = tog;
    end else bus_rdata_i = word_at(a);
  endtask

  // flash model: acts at negedge, ack lasts one cycle
  initial begin
    forever begin
      @(negedge clk_i);
      if (done_o) n_done++;
      if (err_o) n_err++;
      if (watch && !busy_o) busy_err++;
      if (done_o || err_o) watch = 0;
      if (bus_ack_i) begin
        bus_ack_i = 1'b0; pend = 0;
      end else if (bus_req_o) begin
        if (pend && (bus_addr_o != pend_addr || bus_we_o != pend_we || bus_wdata_o != pend_data))
          stab_err++;
        pend = 1; pend_addr = bus_addr_o; pend_we = bus_we_o; pend_data = bus_wdata_o;
        if (wait_cnt == 0) begin
          if (bus_we_o) on_write(bus_addr_o, bus_wdata_o);
          else on_read(bus_addr_o);
          bus_ack_i = 1'b1;
          wait_cnt = $urandom % 3;
        end else wait_cnt--;
      end
    end
  end

  bit hung = 0;

  task automatic run_case(input int lo, input int hi, input logic [1:0] kind, input bit poke,
                          input string tag);
    int mn, exp_er, cyc;
    bit exp_err;
    mn = max_need();
    exp_err = (mn >= LIM + 1);
    exp_er  = exp_err ? LIM : mn;
    seq_pos = 0; n_entry = 0; n_erase = 0; n_exit = 0; n_done = 0; n_err = 0;
    seq_err = 0; poll_err = 0; order_err = 0; resume_err = 0; stab_err = 0; busy_err = 0;
    busy_reads = 0; have_rd = 0; after_erase = 0; max_rd = -1;
    cur_lo = AW'(lo); cur_kind = kind;
    @(negedge clk_i);
    range_lo_i = AW'(lo); range_hi_i = AW'(hi); kind_i = kind; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; watch = 1;
    if (poke) begin
      repeat (20) @(negedge clk_i);
      range_lo_i = AW'(lo + 1); range_hi_i = AW'(hi + 5); kind_i = ~kind; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    cyc = 0;
    while (n_done + n_err == 0 && cyc < 30000) begin @(negedge clk_i); cyc++; end
    if (cyc >= 30000) begin
      hung = 1;
      chk(0, {"WATCHDOG ", tag}, cyc, 0);
      return;
    end
    repeat (2) @(negedge clk_i);
    chk(seq_err == 0 && n_entry == 1, {"R2 command order ", tag}, seq_err, 0);
    chk(poll_err == 0, {"R3 write while busy ", tag}, poll_err, 0);
    chk(order_err == 0, {"R4 scan order ", tag}, order_err, 0);
    chk(resume_err == 0, {"R5 resume address ", tag}, resume_err, 0);
    chk(n_erase == exp_er, {"R6 erase count ", tag}, n_erase, exp_er);
    chk(n_exit == 1, {"R7 exit count ", tag}, n_exit, 1);
    chk(n_done == int'(!exp_err) && n_err == int'(exp_err), {"R8 pulses ", tag},
        n_done * 10 + n_err, exp_err ? 1 : 10);
    chk(busy_err == 0 && !busy_o, {"R8 busy window ", tag}, busy_err, 0);
    chk(stab_err == 0, {"R9 request stability ", tag}, stab_err, 0);
    if (!exp_err) chk(max_rd == hi, {"R4 R1 last address ", tag}, max_rd, hi);
    if (poke) chk(n_entry == 1, {"R1 start while busy ", tag}, n_entry, 1);
  endtask

  initial begin
    void'($urandom(32'h5EED_0C17));
    wait_cnt = 0; tog = 0; n_st = 0; watch = 0; pend = 0;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !bus_req_o && !done_o && !err_o, "R10 reset outputs",
        {busy_o, bus_req_o, done_o, err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !bus_req_o, "R10 idle after reset", busy_o, 0);

    n_st = 0;
    if (!hung) run_case(100, 110, 2'b00, 0, "chip clean");
    n_st = 1; st_addr[0] = 203; st_need[0] = 3;
    if (!hung) run_case(200, 215, 2'b01, 0, "block one stubborn");
    n_st = 2; st_addr[0] = 302; st_need[0] = 2; st_addr[1] = 307; st_need[1] = 4;
    if (!hung) run_case(300, 310, 2'b10, 0, "sector two stubborn");
    n_st = 0;
    if (!hung) run_case(400, 400, 2'b11, 0, "single address kind 11");
    n_st = 1; st_addr[0] = 501; st_need[0] = LIM;
    if (!hung) run_case(500, 504, 2'b01, 0, "limit exactly met");
    n_st = 1; st_addr[0] = 601; st_need[0] = LIM + 1;
    if (!hung) run_case(600, 604, 2'b10, 0, "limit exceeded");
    n_st = 1; st_addr[0] = 700; st_need[0] = 500;
    if (!hung) run_case(700, 703, 2'b00, 0, "stuck first address");

    for (int k = 0; k < 6 && !hung; k++) begin
      int lo = 1000 + k * 100 + ($urandom % 20);
      int len = 1 + ($urandom % 30);
      n_st = $urandom % 4;
      for (int i = 0; i < n_st; i++) begin
        st_addr[i] = lo + 1 + i * 3 + ($urandom % 3);
        st_need[i] = 1 + ($urandom % 6);
      end
      if (len < 14) len = 14;
      run_case(lo, lo + len, 2'($urandom % 4), 1, "random");
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule